// File: doc/BRIEF.md
# Round-Robin Mailbox Access Sequencer

This block shares one mailbox memory among a small set of peripheral controllers by giving each controller an exclusive turn, one after another, once per program interval. A supervisor owns a hold input. While hold is high the sequencer stays parked on the first slot with every interrupt quiet. When the supervisor drops hold, the controller in the current slot receives a one-hot interrupt and owns the mailbox until it finishes or its time runs out.

A controller finishes its turn by raising its read and write strobes together in one cycle. If it never does, a per-slot watchdog of `TMO_CYCLES` clocks takes the turn away. This sets the share of an unresponsive controller; the default of 4500 cycles is 45 us at 100 MHz. The interrupt lines go quiet for one cycle on every slot change, so no controller sees a stray pulse while the index moves. When the last slot is over, the slot counter rests on the value `N_CTRL` and the supervisor receives a completion interrupt. That interrupt stays up until the supervisor raises hold again, which clears the counter for the next interval.

Top module: `mbox_turn_seq`

## Requirements
- R1: While `rst_n` is low, or from the first clock edge at which `sup_hold` is sampled high, `slot` is 0. While `sup_hold` is high, `irq`, `busy` and `sup_irq` are all 0 and every strobe is ignored.
- R2: At the first clock edge at which `sup_hold` is sampled low, bit 0 of `irq` rises, and `slot` reads 0.
- R3: A slot whose controller never completes the handshake keeps its `irq` bit high for exactly `TMO_CYCLES` cycles. At the edge that ends the last of those cycles, `slot` advances by one.
- R4: When the controller whose `irq` bit is high has both `ctl_rd` and `ctl_wr` high in the same cycle, `slot` advances at that cycle's closing edge. The watchdog restarts from zero for the next slot.
- R5: A cycle in which the current controller raises only one of `ctl_rd` or `ctl_wr` does not end its turn.
- R6: Strobes from any controller other than the one in the current slot have no effect on `slot`, `irq` or the watchdog.
- R7: At most one `irq` bit is high at any time. After every change of `slot`, all of `irq` is 0 for exactly one cycle before the next controller's bit rises.
- R8: `slot` holds the binary index of the slot being served. `busy` is high from the release of `sup_hold` until the last slot has ended.
- R9: Once every slot has ended, `slot` equals `N_CTRL`, and `busy` and `irq` are 0. `sup_irq` is 1 and stays 1, with the watchdog stopped, until `sup_hold` goes high.
- R10: A full round never lasts longer than `N_CTRL*(TMO_CYCLES+1)` busy cycles. The first edge after release to `sup_irq` rising is at most `N_CTRL*(TMO_CYCLES+1)-1` cycles, the case in which every slot times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_hold | input | 1 | Supervisor hold; high keeps the sequencer cleared |
| ctl_rd | input | N_CTRL | Read strobe of each controller |
| ctl_wr | input | N_CTRL | Write strobe of each controller |
| irq | output | N_CTRL | One-hot access interrupt to the controllers |
| slot | output | $clog2(N_CTRL)+1 | Current slot index; the value N_CTRL means the round is done |
| busy | output | 1 | A round is in progress |
| sup_irq | output | 1 | Completion interrupt to the supervisor |

## Verification
Every result comes from registers, so a strobe that the bench drives during a cycle shows up on `slot` and `irq` only after the next rising edge. `irq` goes to zero at that edge, and the new controller's bit follows one edge later. On release, bit 0 of `irq` rises at the first edge with hold sampled low, and a timed-out slot's bit stays high for `TMO_CYCLES` cycles. The bench numbers cycles from the first edge after release. From the handshake delay chosen for each slot it computes where every slot starts and how long it lasts. It compares all outputs at each falling edge against that schedule, and drives the strobes for the next edge just after the compare. Because `sup_hold` acts on the outputs without a register, its effect on them is checked one time step after it changes, and its effect on `slot` one edge later.

// File: rtl/mbox_turn_seq.sv
module mbox_turn_seq #(
  parameter int N_CTRL     = 4,
  parameter int TMO_CYCLES = 4500,
  localparam int IW = $clog2(N_CTRL),
  localparam int CW = IW + 1,
  localparam int TW = $clog2(TMO_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_hold,
  input  logic [N_CTRL-1:0] ctl_rd,
  input  logic [N_CTRL-1:0] ctl_wr,
  output logic [N_CTRL-1:0] irq,
  output logic [CW-1:0]     slot,
  output logic              busy,
  output logic              sup_irq
);

  logic [CW-1:0]     slot_q;
  logic              blank_q;
  logic [TW-1:0]     wd_q;
  logic [N_CTRL-1:0] grant_vec;
  logic              active, live, fin, tmo, adv;

  assign grant_vec = N_CTRL'(1) << slot_q[IW-1:0];
  assign active    = !sup_hold && (slot_q < CW'(N_CTRL));
  assign live      = active && !blank_q;
  assign fin       = live && |(grant_vec & ctl_rd & ctl_wr);
  assign tmo       = live && (wd_q == TW'(TMO_CYCLES - 1));
  assign adv       = fin || tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      blank_q <= 1'b1;
      wd_q    <= '0;
    end else if (sup_hold) begin
      slot_q  <= '0;
      blank_q <= 1'b1;
      wd_q    <= '0;
    end else begin
      blank_q <= adv;
      if (adv) begin
        slot_q <= slot_q + 1'b1;
        wd_q   <= '0;
      end else if (live) begin
        wd_q <= wd_q + 1'b1;
      end
    end
  end

  assign irq     = live ? grant_vec : '0;
  assign slot    = slot_q;
  assign busy    = active;
  assign sup_irq = !sup_hold && (slot_q == CW'(N_CTRL));

endmodule

// File: rtl/mbox_turn_seq_chk.sv
module mbox_turn_seq_chk #(
  parameter int N_CTRL     = 4,
  parameter int TMO_CYCLES = 4500,
  localparam int CW = $clog2(N_CTRL) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sup_hold,
  input logic [N_CTRL-1:0] ctl_rd,
  input logic [N_CTRL-1:0] ctl_wr,
  input logic [N_CTRL-1:0] irq,
  input logic [CW-1:0]     slot,
  input logic              busy,
  input logic              sup_irq
);

  int run_q;
  int iv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 0;
    else if (irq == '0) run_q <= 0;
    else run_q <= run_q + 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iv_q <= 0;
    else if (sup_hold) iv_q <= 0;
    else if (busy) iv_q <= iv_q + 1;
  end

  assert_hold_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sup_hold |=> (slot == '0 && irq == '0 && !sup_irq));

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sup_hold) |=> (sup_hold || irq == N_CTRL'(1)));

  assert_wd_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (run_q < TMO_CYCLES));

  assert_handshake_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_hold && (irq & ctl_rd & ctl_wr) != '0) |=> (slot == CW'($past(slot) + 1'b1)));

  assert_stray_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_hold && irq != '0 && (irq & ctl_rd & ctl_wr) == '0 && (run_q + 1 < TMO_CYCLES))
      |=> (sup_hold || slot == $past(slot)));

  assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != $past(slot)) |-> (irq == '0));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sup_irq |-> (!busy && irq == '0 && slot == CW'(N_CTRL)));

  assert_done_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sup_irq |=> (sup_hold || sup_irq));

  assert_round_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (iv_q < N_CTRL * (TMO_CYCLES + 1)));

endmodule

bind mbox_turn_seq mbox_turn_seq_chk #(.N_CTRL(N_CTRL), .TMO_CYCLES(TMO_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .sup_hold(sup_hold), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
  .irq(irq), .slot(slot), .busy(busy), .sup_irq(sup_irq)
);

// File: tb/mbox_turn_seq_tb_top.sv
module mbox_turn_seq_tb_top;
  localparam int N  = 4;
  localparam int T  = 6;
  localparam int CW = $clog2(N) + 1;

  logic clk = 1'b0, rst_n = 1'b0, sup_hold = 1'b1;
  logic [N-1:0] ctl_rd = '0, ctl_wr = '0;
  logic [N-1:0] irq;
  logic [CW-1:0] slot;
  logic busy, sup_irq;
  int n_chk = 0, n_err = 0;

  mbox_turn_seq #(.N_CTRL(N), .TMO_CYCLES(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .sup_hold(sup_hold), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
    .irq(irq), .slot(slot), .busy(busy), .sup_irq(sup_irq));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag, input int e_irq, input int e_slot, input int e_busy, input int e_sup);
    chk(int'(irq) == e_irq, tag, "irq", int'(irq), e_irq);
    chk(int'(slot) == e_slot, tag, "slot", int'(slot), e_slot);
    chk(int'(busy) == e_busy, tag, "busy", int'(busy), e_busy);
    chk(int'(sup_irq) == e_sup, tag, "sup_irq", int'(sup_irq), e_sup);
  endtask

  // dly[s] < 0: slot s times out; otherwise handshake d cycles into its turn
  task automatic run_round(input int dly[N]);
    int len[N];
    int st[N];
    int t_end;
    for (int s = 0; s < N; s++) begin
      len[s] = (dly[s] >= 0) ? dly[s] + 1 : T;
      st[s]  = (s == 0) ? 0 : st[s-1] + len[s-1] + 1;
    end
    t_end = st[N-1] + len[N-1];
    sup_hold = 1'b0;
    ctl_rd = '0; ctl_wr = '0;
    @(posedge clk);
    @(negedge clk);
    for (int t = 0; t <= t_end + 4; t++) begin
      int cur;
      bit in_turn;
      cur = N; in_turn = 0;
      for (int s = 0; s < N; s++) begin
        if (t >= st[s] && t < st[s] + len[s]) begin cur = s; in_turn = 1; end
        else if (t == st[s] + len[s] && t < t_end) cur = s + 1;
      end
      if (t >= t_end) begin
        chk_all((t == N*(T+1)-1) ? "R9 R10" : "R9", 0, N, 0, 1);
      end else if (in_turn) begin
        chk_all((t == 0) ? "R2" : "R3 R4 R5 R6 R8", 1 << cur, cur, 1, 0);
      end else begin
        chk_all("R7", 0, cur, 1, 0);
      end
      ctl_rd = '0; ctl_wr = '0;
      if (in_turn && dly[cur] >= 0 && t == st[cur] + dly[cur]) begin
        ctl_rd[cur] = 1'b1; ctl_wr[cur] = 1'b1;
      end else if (cur < N) begin
        case (t % 3)
          0: ctl_rd[cur] = 1'b1;
          1: ctl_wr[cur] = 1'b1;
          default: begin
            ctl_rd = ~(N'(1) << cur);
            ctl_wr = ~(N'(1) << cur);
          end
        endcase
      end else begin
        ctl_rd = '1; ctl_wr = '1;
      end
      @(negedge clk);
    end
    ctl_rd = '0; ctl_wr = '0;
    sup_hold = 1'b1;
    #1;
    chk(irq == '0 && !busy && !sup_irq, "R1", "outputs on hold", int'({irq, busy, sup_irq}), 0);
    @(negedge clk);
    chk_all("R1", 0, 0, 0, 0);
    ctl_rd = '1; ctl_wr = '1;
    @(negedge clk);
    chk_all("R1", 0, 0, 0, 0);
    ctl_rd = '0; ctl_wr = '0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int d[N];
    repeat (3) @(negedge clk);
    chk_all("R1", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1", 0, 0, 0, 0);
    for (int s = 0; s < N; s++) d[s] = -1;
    run_round(d);
    for (int s = 0; s < N; s++) begin
      for (int k = 0; k < T; k++) begin
        for (int j = 0; j < N; j++) d[j] = -1;
        d[s] = k;
        run_round(d);
      end
    end
    for (int s = 0; s < N; s++) d[s] = 0;
    run_round(d);
    for (int s = 0; s < N; s++) d[s] = (s * 2) % T;
    run_round(d);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule